// File: doc/BRIEF.md
# Vector Zip/Unzip Index Sequencer

This block produces, one per clock, the pair of element positions that a vector register move reads from and writes to. The same move becomes a plain sequential copy, a pack (interleave) or an unpack (deinterleave). The choice depends on whether the source and destination sub-vector length fields match, and on a direction select. The reordering is a transpose over a small two-dimensional matrix whose sizes and axis order are given at start. When the vector is longer than one matrix, the pattern repeats block by block.

Each side carries its own predicate mask. The source walk and the destination walk advance independently, and each skips the positions its mask disables. A pair is emitted only when both sides rest on enabled positions. The run stops as soon as either side has covered the vector length, and a one-cycle completion pulse follows. The register file and the data movement itself belong to the surrounding pipeline. This block only sequences the indices.

Top module: `vzip_index_seq`

## Requirements
- R1: After reset, `busy`, `valid` and `done` are all low.
- R2: A `start` sampled while `busy` is low captures every configuration input. A length above 64 is taken as 64. `busy` is high from the next clock edge until the edge that raises `done`, where it falls.
- R3: When `src_subvl` equals `dst_subvl` (2-bit fields, value v meaning v+1 elements), both walks are linear. The index of step s is s on each side, so with all-ones masks `src_idx` equals `dst_idx` and runs 0, 1, ... vl-1.
- R4: With the fields unequal and `pack_sel`=1 (pack), the destination walk is linear. The source walk is transposed: step s maps to base + i*outer_dim + o, where i is the inner counter and o the outer counter of s.
- R5: With the fields unequal and `pack_sel`=0 (unpack), the source walk is linear and the destination walk is transposed by the same formula.
- R6: The matrix sizes are xdim = `xdim_m1`+1 and ydim = `ydim_m1`+1. With `axis_xy`=0, x varies fastest, so the inner dimension is xdim and the outer is ydim. With `axis_xy`=1 the two swap.
- R7: Steps past xdim*ydim repeat the pattern, with base = (s / (xdim*ydim)) * xdim*ydim. Indices are 6 bits wide.
- R8: Twin predication. Bit p of `src_mask` (`dst_mask`) enables source (destination) position p. Each cycle a side whose current position is disabled advances alone. When both positions are enabled, one pair is emitted and both sides advance. When only one side is disabled, the enabled side holds.
- R9: Every internal step takes one cycle. The outcome of step k (valid and indices) is visible after the k-th edge following the edge that samples `start`. The run ends when either side's step count reaches vl. `done` is high for exactly one cycle, on the edge after the final step, and `valid` is low then.
- R10: A vector length of 0 gives `done` on the first edge after the start edge and no `valid`.
- R11: A `start` sampled while `busy` is high is ignored, and the running sequence is unaffected.
- R12: A `start` presented in the cycle where `done` is high is accepted, since `busy` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (honoured only when idle) |
| vl | input | 7 | Vector length in elements, 0 to 64 |
| pack_sel | input | 1 | 1 = pack (source transposed), 0 = unpack (destination transposed) |
| src_subvl | input | 2 | Source sub-vector length field |
| dst_subvl | input | 2 | Destination sub-vector length field |
| xdim_m1 | input | 3 | Matrix x size minus one |
| ydim_m1 | input | 3 | Matrix y size minus one |
| axis_xy | input | 1 | 0: x fastest, 1: y fastest |
| src_mask | input | 64 | Source predicate, one bit per position |
| dst_mask | input | 64 | Destination predicate, one bit per position |
| busy | output | 1 | A sequence is in progress |
| valid | output | 1 | A pair is presented this cycle |
| src_idx | output | 6 | Source element index |
| dst_idx | output | 6 | Destination element index |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completion of one run and acceptance of the next can share a cycle: `done` is high while `busy` is already low, so a `start` held in that very cycle must open a new run. The bench presents the second start in the `done` cycle of a first run and checks the second run's triples against the one-step-per-edge schedule. Any lost or delayed acceptance shifts every later sample. A start during a run is provoked separately with a different configuration, and the unchanged sequence shows that it was dropped.

// File: rtl/vzip_seq_pkg.sv
package vzip_seq_pkg;
    parameter int VMAX   = 64;
    parameter int IDX_W  = $clog2(VMAX);
    parameter int VL_W   = IDX_W + 1;
    parameter int DIMF_W = 3;
    parameter int DIM_W  = DIMF_W + 1;
    parameter int SUBF_W = 2;
    parameter int NSIDE  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [VL_W-1:0]  vl;
        logic             pack_sel;
        logic             zipped;
        logic             axis_xy;
        logic [DIM_W-1:0] xdim;
        logic [DIM_W-1:0] ydim;
        logic [VMAX-1:0]  smask;
        logic [VMAX-1:0]  dmask;
    } seq_cfg_t;

    typedef struct packed {
        seq_state_e       state;
        seq_cfg_t         cfg;
        logic             valid;
        logic             done;
        logic [IDX_W-1:0] src_idx;
        logic [IDX_W-1:0] dst_idx;
    } seq_regs_t;

    typedef struct packed {
        logic [VL_W-1:0]   step;
        logic [IDX_W-1:0]  base;
        logic [DIMF_W-1:0] inner;
        logic [DIMF_W-1:0] outer;
    } walk_regs_t;
endpackage

// File: rtl/vzip_walker.sv
module vzip_walker
    import vzip_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic             transpose,
    input  logic [DIM_W-1:0] inner_dim,
    input  logic [DIM_W-1:0] outer_dim,
    output logic [VL_W-1:0]  step,
    output logic [IDX_W-1:0] pos
);
    walk_regs_t       w_d, w_q;
    logic [IDX_W-1:0] blk_size_d;
    logic [IDX_W-1:0] tr_pos_d;
    logic             inner_wrap_d;
    logic             outer_wrap_d;

    always_comb begin
        blk_size_d   = IDX_W'(inner_dim) * IDX_W'(outer_dim);
        inner_wrap_d = ({1'b0, w_q.inner} == (inner_dim - DIM_W'(1)));
        outer_wrap_d = ({1'b0, w_q.outer} == (outer_dim - DIM_W'(1)));
        tr_pos_d     = w_q.base
                     + IDX_W'(w_q.inner) * IDX_W'(outer_dim)
                     + IDX_W'(w_q.outer);

        w_d = w_q;
        if (load) begin
            w_d = '0;
        end else if (adv) begin
            w_d.step = w_q.step + VL_W'(1);
            if (inner_wrap_d) begin
                w_d.inner = '0;
                if (outer_wrap_d) begin
                    w_d.outer = '0;
                    w_d.base  = w_q.base + blk_size_d;
                end else begin
                    w_d.outer = w_q.outer + DIMF_W'(1);
                end
            end else begin
                w_d.inner = w_q.inner + DIMF_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign step = w_q.step;
    assign pos  = transpose ? tr_pos_d : w_q.step[IDX_W-1:0];
endmodule

// File: rtl/vzip_step_decide.sv
module vzip_step_decide
    import vzip_seq_pkg::*;
(
    input  logic            run,
    input  logic            src_en,
    input  logic            dst_en,
    input  logic [VL_W-1:0] src_step,
    input  logic [VL_W-1:0] dst_step,
    input  logic [VL_W-1:0] vl,
    output logic            emit,
    output logic            src_adv,
    output logic            dst_adv,
    output logic            finish
);
    logic [VL_W-1:0] src_next_d;
    logic [VL_W-1:0] dst_next_d;

    always_comb begin
        emit       = run & src_en & dst_en;
        // a disabled side moves on alone; an enabled side waits for its partner
        src_adv    = run & (~src_en | dst_en);
        dst_adv    = run & (~dst_en | src_en);
        src_next_d = src_step + VL_W'(src_adv);
        dst_next_d = dst_step + VL_W'(dst_adv);
        finish     = run & ((src_next_d == vl) | (dst_next_d == vl));
    end
endmodule

// File: rtl/vzip_index_seq.sv
module vzip_index_seq
    import vzip_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VL_W-1:0]   vl,
    input  logic              pack_sel,
    input  logic [SUBF_W-1:0] src_subvl,
    input  logic [SUBF_W-1:0] dst_subvl,
    input  logic [DIMF_W-1:0] xdim_m1,
    input  logic [DIMF_W-1:0] ydim_m1,
    input  logic              axis_xy,
    input  logic [VMAX-1:0]   src_mask,
    input  logic [VMAX-1:0]   dst_mask,
    output logic              busy,
    output logic              valid,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              done
);
    seq_regs_t        r_d, r_q;
    logic             accept_d;
    logic             run_d;
    logic [DIM_W-1:0] inner_dim_d;
    logic [DIM_W-1:0] outer_dim_d;
    logic [VL_W-1:0]  vl_clamp_d;

    logic             side_tr   [NSIDE];
    logic             side_adv  [NSIDE];
    logic [VL_W-1:0]  side_step [NSIDE];
    logic [IDX_W-1:0] side_pos  [NSIDE];

    logic             src_en_d;
    logic             dst_en_d;
    logic             emit_d;
    logic             src_adv_d;
    logic             dst_adv_d;
    logic             finish_d;

    logic [VL_W-1:0]  cur_vl;
    logic [VMAX-1:0]  cur_smask;
    logic [VMAX-1:0]  cur_dmask;

    always_comb begin
        accept_d    = start & (r_q.state == ST_IDLE);
        run_d       = (r_q.state == ST_RUN);
        inner_dim_d = r_q.cfg.axis_xy ? r_q.cfg.ydim : r_q.cfg.xdim;
        outer_dim_d = r_q.cfg.axis_xy ? r_q.cfg.xdim : r_q.cfg.ydim;
        vl_clamp_d  = (vl > VL_W'(VMAX)) ? VL_W'(VMAX) : vl;
        side_tr[0]  = r_q.cfg.zipped &  r_q.cfg.pack_sel;
        side_tr[1]  = r_q.cfg.zipped & ~r_q.cfg.pack_sel;
        side_adv[0] = src_adv_d;
        side_adv[1] = dst_adv_d;
        src_en_d    = r_q.cfg.smask[side_pos[0]];
        dst_en_d    = r_q.cfg.dmask[side_pos[1]];
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        vzip_walker u_walk (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (accept_d),
            .adv       (side_adv[g]),
            .transpose (side_tr[g]),
            .inner_dim (inner_dim_d),
            .outer_dim (outer_dim_d),
            .step      (side_step[g]),
            .pos       (side_pos[g])
        );
    end

    vzip_step_decide u_decide (
        .run      (run_d),
        .src_en   (src_en_d),
        .dst_en   (dst_en_d),
        .src_step (side_step[0]),
        .dst_step (side_step[1]),
        .vl       (r_q.cfg.vl),
        .emit     (emit_d),
        .src_adv  (src_adv_d),
        .dst_adv  (dst_adv_d),
        .finish   (finish_d)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.done  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept_d) begin
                    r_d.cfg.vl       = vl_clamp_d;
                    r_d.cfg.pack_sel = pack_sel;
                    r_d.cfg.zipped   = (src_subvl != dst_subvl);
                    r_d.cfg.axis_xy  = axis_xy;
                    r_d.cfg.xdim     = {1'b0, xdim_m1} + DIM_W'(1);
                    r_d.cfg.ydim     = {1'b0, ydim_m1} + DIM_W'(1);
                    r_d.cfg.smask    = src_mask;
                    r_d.cfg.dmask    = dst_mask;
                    r_d.state        = (vl_clamp_d == '0) ? ST_DRAIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (emit_d) begin
                    r_d.valid   = 1'b1;
                    r_d.src_idx = side_pos[0];
                    r_d.dst_idx = side_pos[1];
                end
                if (finish_d) begin
                    r_d.state = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign valid     = r_q.valid;
    assign src_idx   = r_q.src_idx;
    assign dst_idx   = r_q.dst_idx;
    assign done      = r_q.done;
    assign cur_vl    = r_q.cfg.vl;
    assign cur_smask = r_q.cfg.smask;
    assign cur_dmask = r_q.cfg.dmask;
endmodule

// File: rtl/vzip_index_seq_chk.sv
module vzip_index_seq_chk
    import vzip_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VL_W-1:0]  vl,
    input logic             busy,
    input logic             valid,
    input logic [IDX_W-1:0] src_idx,
    input logic [IDX_W-1:0] dst_idx,
    input logic             done,
    input logic [VL_W-1:0]  cfg_vl,
    input logic [VMAX-1:0]  cfg_smask,
    input logic [VMAX-1:0]  cfg_dmask
);
    logic [VL_W:0] emitted_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emitted_q <= '0;
        end else if (start && !busy) begin
            emitted_q <= '0;
        end else if (valid) begin
            emitted_q <= emitted_q + 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !valid && !done));

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r8_both_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cfg_smask[src_idx] && cfg_dmask[dst_idx]));

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ({1'b0, emitted_q} < {1'b0, cfg_vl, 1'b0} >> 1));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !valid));

    a_r10_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl == '0) |=> (!valid ##1 (done && !valid)));

    a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_vl) && $stable(cfg_smask) && $stable(cfg_dmask)));
endmodule

bind vzip_index_seq vzip_index_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl        (vl),
    .busy      (busy),
    .valid     (valid),
    .src_idx   (src_idx),
    .dst_idx   (dst_idx),
    .done      (done),
    .cfg_vl    (cur_vl),
    .cfg_smask (cur_smask),
    .cfg_dmask (cur_dmask)
);

// File: tb/sim_vzip_index_seq.sv
`timescale 1ns/1ps
module sim_vzip_index_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic        pack_sel = 1'b0;
    logic [1:0]  src_subvl = '0;
    logic [1:0]  dst_subvl = '0;
    logic [2:0]  xdim_m1 = '0;
    logic [2:0]  ydim_m1 = '0;
    logic        axis_xy = 1'b0;
    logic [63:0] src_mask = '0;
    logic [63:0] dst_mask = '0;
    logic        busy, valid, done;
    logic [5:0]  src_idx, dst_idx;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vzip_index_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pack_sel(pack_sel),
        .src_subvl(src_subvl), .dst_subvl(dst_subvl), .xdim_m1(xdim_m1),
        .ydim_m1(ydim_m1), .axis_xy(axis_xy), .src_mask(src_mask),
        .dst_mask(dst_mask), .busy(busy), .valid(valid), .src_idx(src_idx),
        .dst_idx(dst_idx), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] mpos(input int step, input bit tr,
                                        input int inn, input int outd);
        int sz, base, r, t;
        sz   = inn * outd;
        base = (step / sz) * sz;
        r    = step % sz;
        t    = tr ? base + (r % inn) * outd + (r / inn) : step;
        return t[5:0];
    endfunction

    // Called just after a falling edge; returns just after the falling edge of the done cycle.
    task automatic run_case(input string tag, input int n_vl, input bit psel,
                            input int ssub, input int dsub, input int xd, input int yd,
                            input bit axy, input logic [63:0] sm, input logic [63:0] dm,
                            input int inj);
        bit ev [130];
        int es [130];
        int ed [130];
        int n, ss, ds, inn, outd, evl;
        bit zip, str, dtr, sen, den;
        logic [5:0] sp, dp;
        evl  = (n_vl > 64) ? 64 : n_vl;
        zip  = (ssub != dsub);
        str  = zip && psel;
        dtr  = zip && !psel;
        inn  = axy ? yd : xd;
        outd = axy ? xd : yd;
        n = 0; ss = 0; ds = 0;
        while (ss < evl && ds < evl) begin
            sp  = mpos(ss, str, inn, outd);
            dp  = mpos(ds, dtr, inn, outd);
            sen = sm[sp];
            den = dm[dp];
            n++;
            ev[n] = sen && den;
            es[n] = int'(sp);
            ed[n] = int'(dp);
            if (sen && den) begin
                ss++; ds++;
            end else begin
                if (!sen) ss++;
                if (!den) ds++;
            end
        end
        vl = 7'(n_vl); pack_sel = psel; src_subvl = 2'(ssub); dst_subvl = 2'(dsub);
        xdim_m1 = 3'(xd - 1); ydim_m1 = 3'(yd - 1); axis_xy = axy;
        src_mask = sm; dst_mask = dm; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (inj != 0 && k == inj + 1) start = 1'b0;
            if (k <= n) begin
                chk(valid == ev[k], tag, "valid", int'(valid), int'(ev[k]));
                if (ev[k]) begin
                    chk(int'(src_idx) == es[k], tag, "src_idx", int'(src_idx), es[k]);
                    chk(int'(dst_idx) == ed[k], tag, "dst_idx", int'(dst_idx), ed[k]);
                end
                chk(done == 1'b0, "R9", "done early", int'(done), 0);
                chk(busy == 1'b1, "R2", "busy in run", int'(busy), 1);
            end else begin
                chk(done == 1'b1, "R9", "done pulse", int'(done), 1);
                chk(valid == 1'b0, "R9", "valid at done", int'(valid), 0);
                chk(busy == 1'b0, "R2", "busy at done", int'(busy), 0);
            end
            if (inj != 0 && k == inj) begin
                // R11: a new request with a different shape while the run is in flight
                vl = 7'd5; pack_sel = ~psel; src_subvl = 2'd3; dst_subvl = 2'd0;
                xdim_m1 = 3'd0; ydim_m1 = 3'd4; src_mask = '1; dst_mask = '1;
                start = 1'b1;
            end
        end
    endtask

    task automatic idle_gap();
        @(negedge clk);
        chk(done == 1'b0, "R9", "done after pulse", int'(done), 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0,  "R1", "busy", int'(busy), 0);
        chk(valid == 1'b0, "R1", "valid", int'(valid), 0);
        chk(done == 1'b0,  "R1", "done", int'(done), 0);
    endtask

    task automatic t_copy();
        run_case("R3", 8, 1'b1, 2, 2, 2, 4, 1'b0, '1, '1, 0);
        idle_gap();
        run_case("R3", 64, 1'b0, 1, 1, 8, 8, 1'b0, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_pack();
        run_case("R4", 9, 1'b1, 0, 2, 3, 3, 1'b0, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_unpack();
        run_case("R5", 8, 1'b0, 1, 0, 2, 4, 1'b0, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_axis();
        run_case("R6", 6, 1'b1, 0, 3, 2, 3, 1'b1, '1, '1, 0);
        idle_gap();
        run_case("R6", 12, 1'b0, 3, 1, 4, 3, 1'b1, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_blocks();
        run_case("R7", 16, 1'b1, 0, 1, 2, 2, 1'b0, '1, '1, 0);
        idle_gap();
        run_case("R7", 48, 1'b0, 2, 0, 4, 4, 1'b1, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_pred();
        run_case("R8", 8, 1'b0, 1, 1, 1, 1, 1'b0, 64'hB5, 64'h6E, 0);
        idle_gap();
        run_case("R8", 9, 1'b1, 0, 2, 3, 3, 1'b0, 64'h1DB, 64'h0F7, 0);
        idle_gap();
        run_case("R8", 16, 1'b0, 0, 1, 4, 4, 1'b0, 64'hFFFF, 64'h00F0, 0);
        idle_gap();
    endtask

    task automatic t_empty();
        run_case("R10", 0, 1'b1, 0, 1, 2, 2, 1'b0, '1, '1, 0);
        idle_gap();
    endtask

    task automatic t_ignore();
        run_case("R11", 10, 1'b1, 0, 1, 5, 2, 1'b0, 64'h3FB, '1, 3);
        idle_gap();
    endtask

    task automatic t_back_to_back();
        run_case("R12", 4, 1'b1, 0, 0, 2, 2, 1'b0, '1, '1, 0);
        run_case("R12", 6, 1'b1, 1, 2, 3, 2, 1'b0, '1, 64'h3D, 0);
        idle_gap();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_copy();
        t_pack();
        t_unpack();
        t_axis();
        t_blocks();
        t_pred();
        t_empty();
        t_ignore();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule